// File: doc/BRIEF.md
# Gated Back-EMF Zero-Crossing Detector

This block sits between three external back-EMF comparators and the commutation logic of a sensorless six-step motor drive. Each comparator reports whether one phase terminal is above or below half the bus voltage. During the PWM off-time that signal carries the switching carrier, so it cannot be used directly.

The block synchronises the three comparator bits to the clock. It uses the current commutation sector to pick the one phase that is not driven. It reads that phase only during the PWM on-time, and only after a programmable settling delay has passed. The last reading is held through the off-time, which strips the carrier from the signal.

The held level is compared with the crossing direction expected for the present sector and rotation direction. When the level changes the expected way, the block emits a single-cycle event for the commutation timer. After that event it ignores further crossings until the step changes.

Top module: `zc_sampler`

## Requirements
- R1: `held_o` changes only on a clock edge at which `pwm_i` is high; while `pwm_i` is low, `held_o` keeps its value whatever the comparator inputs do.
- R2: With `blank_i` = B, the first B+1 clock edges of each high period of `pwm_i` (the edge that first sees `pwm_i` high counts as the first) take no sample. A high period of B+1 edges or fewer therefore leaves `held_o` unchanged, and one of B+2 edges takes a sample.
- R3: The observed comparator bit depends on `sector_i`: sectors 0 and 3 use `cmp_i[2]`, sectors 1 and 4 use `cmp_i[1]`, and sectors 2 and 5 use `cmp_i[0]`. The other two bits have no effect.
- R4: `zc_o` pulses high for exactly one cycle when a sample changes `held_o` in the expected direction. The pulse is high in the cycle that starts with the sampling edge, which is the same edge that updates `held_o`.
- R5: With `dir_rev_i` = 0, the expected crossing is rising (0 to 1) in sectors 0, 2 and 4, and falling (1 to 0) in sectors 1, 3 and 5. A change in the other direction produces no pulse.
- R6: With `dir_rev_i` = 1, the expected crossing of every sector is inverted.
- R7: Within one step, only the first qualifying crossing is reported. A step ends when `sector_i` or `dir_rev_i` changes, and later crossings in the same step produce no pulse.
- R8: The first sample taken after a step change only loads the new phase's level into `held_o`. It produces no pulse, even if that level differs from the previous held value.
- R9: For `sector_i` values 6 and 7, no sample is taken and `zc_o` stays low.
- R10: Each comparator bit passes through two synchroniser flops. A change made while sampling is active appears on `held_o` at the third clock edge after it.
- R11: While `rst_n` is low, `held_o` and `zc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM gate; high means on-time |
| cmp_i | input | 3 | Comparator outputs, bit 0 = phase A, bit 1 = B, bit 2 = C |
| sector_i | input | 3 | Commutation sector, 0 to 5 |
| dir_rev_i | input | 1 | 1 selects reverse rotation |
| blank_i | input | BLANK_W | Blanking delay in clock cycles after the PWM rise |
| held_o | output | 1 | Held, carrier-free sample of the floating phase |
| zc_o | output | 1 | Single-cycle zero-crossing event |

## Verification
The bench toggles the observed comparator only during the off-time and restores it before the on-time. This distinguishes true gating from a design that samples continuously.

High periods of exactly B+1 and B+2 edges bracket the blanking count. Each sector is driven with crossings in both directions, under both rotation settings, so that a wrong polarity table or an un-inverted direction shows up as a missing or extra pulse. The bench also toggles the non-floating bits, uses invalid sectors, and switches steps so that the stale held level looks like a crossing. These cases separate correct phase selection and re-arming from near misses. A change made in mid on-time fixes the synchroniser latency and the exact cycle of the pulse.

// File: rtl/zc_sampler.sv
module zc_sampler #(
  parameter int BLANK_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_i,
  input  logic [2:0]         cmp_i,
  input  logic [2:0]         sector_i,
  input  logic               dir_rev_i,
  input  logic [BLANK_W-1:0] blank_i,
  output logic               held_o,
  output logic               zc_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] sync_q [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= '0;
      else if (g == 0) sync_q[g] <= cmp_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
    end
  end

  // sector table: floating phase index and base rising polarity
  logic [1:0] float_idx;
  logic       sec_valid;
  logic       base_rise;

  always_comb begin
    sec_valid = 1'b1;
    case (sector_i)
      3'd0, 3'd3: float_idx = 2'd2;
      3'd1, 3'd4: float_idx = 2'd1;
      3'd2, 3'd5: float_idx = 2'd0;
      default: begin
        float_idx = 2'd0;
        sec_valid = 1'b0;
      end
    endcase
  end

  assign base_rise = ~sector_i[0];

  logic cmp_float;
  logic exp_lvl;

  assign cmp_float = sync_q[LAST][float_idx];
  assign exp_lvl   = base_rise ^ dir_rev_i;

  // blanking after each PWM rise
  logic               pwm_q;
  logic [BLANK_W-1:0] blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      blank_q <= '0;
    end else begin
      pwm_q <= pwm_i;
      if (pwm_i && !pwm_q) blank_q <= blank_i;
      else if (pwm_i && blank_q != '0) blank_q <= blank_q - 1'b1;
    end
  end

  // step tracking
  logic [2:0] sector_q;
  logic       dir_q;
  logic       step_chg;

  assign step_chg = (sector_i != sector_q) || (dir_rev_i != dir_q);

  logic sample_en;
  assign sample_en = pwm_i && pwm_q && (blank_q == '0) && sec_valid && !step_chg;

  logic held_q, ref_ok, armed, zc_q;
  logic hit;

  assign hit = ref_ok && armed && (cmp_float != held_q) && (cmp_float == exp_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_q <= '0;
      dir_q    <= 1'b0;
      held_q   <= 1'b0;
      ref_ok   <= 1'b0;
      armed    <= 1'b1;
      zc_q     <= 1'b0;
    end else begin
      sector_q <= sector_i;
      dir_q    <= dir_rev_i;
      zc_q     <= 1'b0;
      if (step_chg) begin
        armed  <= 1'b1;
        ref_ok <= 1'b0;
      end else if (sample_en) begin
        held_q <= cmp_float;
        ref_ok <= 1'b1;
        if (hit) begin
          zc_q  <= 1'b1;
          armed <= 1'b0;
        end
      end
    end
  end

  assign held_o = held_q;
  assign zc_o   = zc_q;

  p_hold_off_time_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_i |=> $stable(held_o));

  p_rise_edge_blanked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_i) |=> $stable(held_o));

  p_pulse_is_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zc_o |-> (held_o != $past(held_o)));

  p_pulse_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zc_o |-> (held_o == $past(exp_lvl)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zc_o |=> !zc_o);

  p_invalid_sector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_i > 3'd5) |=> (!zc_o && $stable(held_o)));

  p_needs_pwm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zc_o |-> $past(pwm_i));

endmodule

// File: tb/zc_sampler_bench.sv
module zc_sampler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic [2:0] cmp = 3'b000;
  logic [2:0] sector = 3'd0;
  logic       dir_rev = 1'b0;
  logic [7:0] blank = 8'(BLANK);
  logic       held, zc;

  int checks = 0;
  int errors = 0;
  int zc_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_sampler u_zc_sampler (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .cmp_i(cmp), .sector_i(sector),
    .dir_rev_i(dir_rev), .blank_i(blank), .held_o(held), .zc_o(zc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_pwm(input int hi, input int lo);
    pwm = 1'b1;
    repeat (hi) begin @(negedge clk); zc_cnt += int'(zc); end
    pwm = 1'b0;
    repeat (lo) begin @(negedge clk); zc_cnt += int'(zc); end
  endtask

  task automatic restep(input logic [2:0] s, input logic d);
    sector = 3'd7;
    repeat (2) @(negedge clk);
    sector = s;
    dir_rev = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 held in reset", int'(held), 0);
    chk("R11 zc in reset", int'(zc), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_basic_rise;
    restep(3'd0, 1'b0);
    cmp = 3'b000; run_pwm(10, 6);
    zc_cnt = 0;
    cmp = 3'b100; run_pwm(10, 6);
    chk("R5 sector0 rising pulses", zc_cnt, 1);
    chk("R5 sector0 held", int'(held), 1);
  endtask

  task automatic t_carrier;
    restep(3'd1, 1'b0);
    cmp = 3'b010; run_pwm(10, 6);
    zc_cnt = 0;
    pwm = 1'b0;
    cmp = 3'b000; repeat (4) @(negedge clk);
    zc_cnt += int'(zc);
    cmp = 3'b010; repeat (4) @(negedge clk);
    run_pwm(10, 6);
    chk("R1 off-time toggle held", int'(held), 1);
    chk("R1 off-time toggle pulses", zc_cnt, 0);
    cmp = 3'b000; run_pwm(10, 6);
    chk("R5 sector1 falling pulses", zc_cnt, 1);
    cmp = 3'b010; run_pwm(10, 6);
    cmp = 3'b000; run_pwm(10, 6);
    chk("R7 later crossings ignored", zc_cnt, 1);
  endtask

  task automatic t_blank;
    restep(3'd2, 1'b0);
    cmp = 3'b000; run_pwm(10, 6);
    zc_cnt = 0;
    cmp = 3'b001; repeat (4) @(negedge clk);
    run_pwm(BLANK + 1, 6);
    chk("R2 short high period held", int'(held), 0);
    chk("R2 short high period pulses", zc_cnt, 0);
    run_pwm(BLANK + 2, 6);
    chk("R2 boundary period held", int'(held), 1);
    chk("R2 boundary period pulses", zc_cnt, 1);
  endtask

  task automatic t_direction;
    restep(3'd0, 1'b1);
    cmp = 3'b100; run_pwm(10, 6);
    zc_cnt = 0;
    cmp = 3'b000; run_pwm(10, 6);
    chk("R6 sector0 reversed falling", zc_cnt, 1);
    restep(3'd1, 1'b1);
    cmp = 3'b010; run_pwm(10, 6);
    zc_cnt = 0;
    cmp = 3'b000; run_pwm(10, 6);
    chk("R6 sector1 reversed falling ignored", zc_cnt, 0);
    cmp = 3'b010; run_pwm(10, 6);
    chk("R6 sector1 reversed rising", zc_cnt, 1);
  endtask

  task automatic t_stale_ref;
    restep(3'd4, 1'b0);
    cmp = 3'b010; run_pwm(10, 6);
    chk("R8 setup held", int'(held), 1);
    zc_cnt = 0;
    sector = 3'd3;
    cmp = 3'b000;
    repeat (4) @(negedge clk);
    run_pwm(10, 6);
    chk("R8 first sample no pulse", zc_cnt, 0);
    chk("R8 first sample loads held", int'(held), 0);
  endtask

  task automatic t_phase_select;
    restep(3'd5, 1'b0);
    cmp = 3'b111; run_pwm(10, 6);
    zc_cnt = 0;
    cmp = 3'b110; run_pwm(10, 6);
    chk("R3 sector5 uses bit0", zc_cnt, 1);
    restep(3'd0, 1'b0);
    cmp = 3'b000; run_pwm(10, 6);
    zc_cnt = 0;
    cmp = 3'b011; run_pwm(10, 6);
    cmp = 3'b001; run_pwm(10, 6);
    chk("R3 non-floating bits no pulse", zc_cnt, 0);
    chk("R3 non-floating bits held", int'(held), 0);
  endtask

  task automatic t_invalid;
    restep(3'd2, 1'b0);
    cmp = 3'b000; run_pwm(10, 6);
    sector = 3'd6;
    zc_cnt = 0;
    cmp = 3'b111; run_pwm(10, 6);
    chk("R9 sector6 held", int'(held), 0);
    chk("R9 sector6 pulses", zc_cnt, 0);
  endtask

  task automatic t_latency;
    restep(3'd2, 1'b0);
    cmp = 3'b000;
    pwm = 1'b1;
    repeat (12) @(negedge clk);
    cmp = 3'b001;
    repeat (2) @(negedge clk);
    chk("R10 held after two edges", int'(held), 0);
    @(negedge clk);
    chk("R10 held after three edges", int'(held), 1);
    chk("R4 pulse with held update", int'(zc), 1);
    @(negedge clk);
    chk("R4 pulse lasts one cycle", int'(zc), 0);
    pwm = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic_rise();
    t_carrier();
    t_blank();
    t_direction();
    t_stale_ref();
    t_phase_select();
    t_invalid();
    t_latency();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule